// File: doc/BRIEF.md
# Video Crop and Decimation Window

This block sits on a decoded video pixel stream. In every field it picks out a rectangle of pixels and thins that rectangle down to a programmed output size. Its inputs are a pixel valid strobe, one-cycle horizontal and vertical sync pulses, and a field identifier. Pixels are only ever dropped. They are never blended. The pixels that pass are marked by an output valid qualifier, which comes with markers for the first kept pixel of each line and the first kept pixel of each field. A downstream packer uses these markers.

The window is set by a delay, an active length and a scale, given separately for each axis. Delay and active are 10-bit values. Scale is a 12-bit value equal to (active size / output size) x 256, so 256 means 1:1. Vertical values count lines within one field. The values are loaded through a byte-wide register file. Each value has its low byte in its own register, and the upper bits are packed into two shared registers. Register writes land in a shadow copy. The shadow copy is transferred to the working settings at the next vertical sync, so a field is always cropped with one consistent set of values.

Decimation in each axis uses an 8.8 fixed-point accumulator. Each step inside the window adds 256. When the sum reaches the effective scale, the step is kept and the scale is subtracted from the sum.

Top module: `vid_crop_scale`

## Requirements
- R1: During and right after reset, out_valid, out_line_start, out_field_start and out_field are all 0.
- R2: After each hsync, pixels are numbered 0, 1, 2, ... and only cycles with pix_valid high advance the count. Pixels numbered below the horizontal delay are never emitted.
- R3: Pixels numbered at or above horizontal delay + horizontal active are never emitted.
- R4: Horizontal decimation works on each in-window pixel. The accumulator (cleared at hsync) has 256 added to it. The pixel is emitted when the sum is at least the effective scale, and the scale is then subtracted. A scale of 256 keeps every in-window pixel.
- R5: Lines are numbered by the hsync pulses that follow a vsync, and the first hsync starts line 0. Lines numbered below the vertical delay, or at or above vertical delay + vertical active, emit nothing.
- R6: Vertical decimation applies the R4 rule once per in-window line. The line accumulator is cleared at vsync. A line that is not kept emits nothing.
- R7: A scale value below 256, including 0, behaves exactly like 256.
- R8: The register map, by 3-bit address, is: 0 = crop-high, 1 = vertical delay low, 2 = vertical active low, 3 = horizontal delay low, 4 = horizontal active low, 5 = scale-high, 6 = vertical scale low, 7 = horizontal scale low. In crop-high, bits 7:6 hold vertical delay bits 9:8, bits 5:4 hold vertical active bits 9:8, bits 3:2 hold horizontal delay bits 9:8, and bits 1:0 hold horizontal active bits 9:8. In scale-high, bits 7:4 hold vertical scale bits 11:8 and bits 3:0 hold horizontal scale bits 11:8.
- R9: Register writes have no effect on the field in progress. All eight shadow bytes take effect together at the next vsync.
- R10: out_line_start is high together with the first emitted pixel of each line. out_field_start is high together with the first emitted pixel of each field. out_field holds the value of field_in sampled at the last vsync.
- R11: A pixel presented in the same cycle as hsync or vsync is ignored. An emitted pixel appears on the outputs one clock after its input cycle.
- R12: After reset, the working settings describe 625-line timing. These are vertical delay 24, vertical active 288, horizontal delay 3, horizontal active 720, and both scales 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Input pixel strobe |
| pix_data | input | PIX_W | Input pixel value |
| hsync | input | 1 | One-cycle line start pulse |
| vsync | input | 1 | One-cycle field start pulse |
| field_in | input | 1 | Field identity, sampled at vsync |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_data | input | 8 | Register write data |
| out_valid | output | 1 | Emitted pixel qualifier |
| out_data | output | PIX_W | Emitted pixel value |
| out_line_start | output | 1 | First emitted pixel of a line |
| out_field_start | output | 1 | First emitted pixel of a field |
| out_field | output | 1 | Field identity of the current field |

## Verification
A horizontal position or accumulator that has slipped by even one step shows up in the very next line. The kept pixels shift or change their spacing, and the single-cycle comparison of out_valid and out_data catches this at the first misplaced pixel. A corrupted line counter or vertical accumulator shows up as a whole line that appears or goes missing. Register decode or commit-timing faults only become visible at the first field after the relevant vsync. For this reason every field's emitted-pixel count is also compared against a closed-form total.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

    localparam int LEN_W   = 10;
    localparam int SCALE_W = 12;
    localparam int CNT_W   = LEN_W + 1;
    localparam int ACC_W   = SCALE_W + 1;
    localparam int UNITY   = 256;
    localparam int NREGS   = 8;

    typedef enum logic [2:0] {
        RA_CROP_HI  = 3'd0,
        RA_VDLY_LO  = 3'd1,
        RA_VACT_LO  = 3'd2,
        RA_HDLY_LO  = 3'd3,
        RA_HACT_LO  = 3'd4,
        RA_SCALE_HI = 3'd5,
        RA_VSCL_LO  = 3'd6,
        RA_HSCL_LO  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [LEN_W-1:0]   vdelay;
        logic [LEN_W-1:0]   vactive;
        logic [LEN_W-1:0]   hdelay;
        logic [LEN_W-1:0]   hactive;
        logic [SCALE_W-1:0] vscale;
        logic [SCALE_W-1:0] hscale;
    } win_cfg_t;

    typedef logic [NREGS-1:0][7:0] reg_bank_t;

    // Reset contents: 625-line timing, unity scale in both axes.
    function automatic logic [7:0] reset_byte(input int idx);
        case (idx)
            0:       return 8'h12;
            1:       return 8'h18;
            2:       return 8'h20;
            3:       return 8'h03;
            4:       return 8'hD0;
            5:       return 8'h11;
            default: return 8'h00;
        endcase
    endfunction

    function automatic win_cfg_t decode_bank(input reg_bank_t r);
        win_cfg_t c;
        c.vdelay  = {r[int'(RA_CROP_HI)][7:6], r[int'(RA_VDLY_LO)]};
        c.vactive = {r[int'(RA_CROP_HI)][5:4], r[int'(RA_VACT_LO)]};
        c.hdelay  = {r[int'(RA_CROP_HI)][3:2], r[int'(RA_HDLY_LO)]};
        c.hactive = {r[int'(RA_CROP_HI)][1:0], r[int'(RA_HACT_LO)]};
        c.vscale  = {r[int'(RA_SCALE_HI)][7:4], r[int'(RA_VSCL_LO)]};
        c.hscale  = {r[int'(RA_SCALE_HI)][3:0], r[int'(RA_HSCL_LO)]};
        return c;
    endfunction

    // Scales below unity cannot add pixels, so they act as unity.
    function automatic logic [ACC_W-1:0] eff_scale(input logic [SCALE_W-1:0] s);
        if (s < SCALE_W'(UNITY)) return ACC_W'(UNITY);
        return ACC_W'(s);
    endfunction

endpackage

// File: rtl/vcs_regs.sv
module vcs_regs
    import vcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       commit,
    output win_cfg_t   cfg
);

    reg_bank_t shadow;
    reg_bank_t reset_bank;

    genvar gi;
    generate
        for (gi = 0; gi < NREGS; gi++) begin : g_byte
            assign reset_bank[gi] = reset_byte(gi);
            always_ff @(posedge clk) begin
                if (rst)
                    shadow[gi] <= reset_byte(gi);
                else if (wr_en && (wr_addr == 3'(gi)))
                    shadow[gi] <= wr_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= decode_bank(reset_bank);
        else if (commit)
            cfg <= decode_bank(shadow);
    end

    // R9: working settings move only on a field boundary
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(cfg));

endmodule

// File: rtl/vcs_axis.sv
module vcs_axis
    import vcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               step,
    input  logic [LEN_W-1:0]   delay,
    input  logic [LEN_W-1:0]   active,
    input  logic [SCALE_W-1:0] scale,
    output logic               keep
);

    logic [CNT_W-1:0] pos;
    logic [ACC_W-1:0] acc;
    logic [CNT_W-1:0] win_end;
    logic [ACC_W-1:0] eff;
    logic [ACC_W-1:0] sum;
    logic             in_win;
    logic             hit;

    always_comb begin
        win_end = CNT_W'(delay) + CNT_W'(active);
        in_win  = (pos >= CNT_W'(delay)) && (pos < win_end);
        eff     = eff_scale(scale);
        sum     = acc + ACC_W'(UNITY);
        hit     = in_win && (sum >= eff);
        keep    = step && !restart && hit;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pos <= '0;
            acc <= '0;
        end else if (step) begin
            if (pos != '1)
                pos <= pos + 1'b1;
            if (in_win)
                acc <= hit ? (sum - eff) : sum;
        end
    end

    // R4: the residue left after each step stays below the scale
    assert_acc_below_scale_R4: assert property (@(posedge clk) disable iff (rst)
        acc < eff);

    // R5: once past the window end nothing further is kept on this axis
    assert_no_keep_past_end_R5: assert property (@(posedge clk) disable iff (rst)
        (pos >= win_end) |-> !keep);

endmodule

// File: rtl/vid_crop_scale.sv
module vid_crop_scale
    import vcs_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             hsync,
    input  logic             vsync,
    input  logic             field_in,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_addr,
    input  logic [7:0]       cfg_data,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    output logic             out_line_start,
    output logic             out_field_start,
    output logic             out_field
);

    win_cfg_t cfg;
    logic     v_keep;
    logic     h_keep;
    logic     line_on;
    logic     line_pend;
    logic     field_pend;
    logic     emit;

    vcs_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .commit  (vsync),
        .cfg     (cfg)
    );

    vcs_axis u_vert (
        .clk     (clk),
        .rst     (rst),
        .restart (vsync),
        .step    (hsync),
        .delay   (cfg.vdelay),
        .active  (cfg.vactive),
        .scale   (cfg.vscale),
        .keep    (v_keep)
    );

    vcs_axis u_horz (
        .clk     (clk),
        .rst     (rst),
        .restart (hsync | vsync),
        .step    (pix_valid),
        .delay   (cfg.hdelay),
        .active  (cfg.hactive),
        .scale   (cfg.hscale),
        .keep    (h_keep)
    );

    assign emit = h_keep && line_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_on    <= 1'b0;
            line_pend  <= 1'b0;
            field_pend <= 1'b0;
        end else if (vsync) begin
            line_on    <= 1'b0;
            line_pend  <= 1'b0;
            field_pend <= 1'b1;
        end else if (hsync) begin
            line_on    <= v_keep;
            line_pend  <= 1'b1;
        end else if (emit) begin
            line_pend  <= 1'b0;
            field_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid       <= 1'b0;
            out_data        <= '0;
            out_line_start  <= 1'b0;
            out_field_start <= 1'b0;
            out_field       <= 1'b0;
        end else begin
            out_valid       <= emit;
            out_line_start  <= emit && line_pend;
            out_field_start <= emit && field_pend;
            if (emit)
                out_data <= pix_data;
            if (vsync)
                out_field <= field_in;
        end
    end

    // R11: every emitted pixel traces back to a plain pixel cycle
    assert_emit_from_pixel_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(pix_valid && !hsync && !vsync));

    // R10: line marker only rides on an emitted pixel
    assert_line_mark_valid_R10: assert property (@(posedge clk) disable iff (rst)
        out_line_start |-> out_valid);

    // R10: first pixel of a field is also first of its line
    assert_field_mark_line_R10: assert property (@(posedge clk) disable iff (rst)
        out_field_start |-> out_line_start);

    // R10: field identity changes only after a vsync
    assert_field_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(vsync) |-> $stable(out_field));

endmodule

// File: tb/vid_crop_scale_test.sv
module vid_crop_scale_test;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          pix_valid, hsync, vsync, field_in, cfg_wr;
    logic [PW-1:0] pix_data;
    logic [2:0]    cfg_addr;
    logic [7:0]    cfg_data;
    logic          out_valid, out_line_start, out_field_start, out_field;
    logic [PW-1:0] out_data;

    always #2 clk = ~clk;

    vid_crop_scale #(.PIX_W(PW)) uut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
        .hsync(hsync), .vsync(vsync), .field_in(field_in),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_data(out_data),
        .out_line_start(out_line_start), .out_field_start(out_field_start),
        .out_field(out_field)
    );

    int    checks = 0;
    int    errors = 0;
    int    nemit  = 0;
    bit    finished = 0;
    string tag = "R1";

    // bench model state
    bit [7:0] shadow [8];
    bit [7:0] act [8];
    int  m_vcnt, m_vacc, m_hcnt, m_hacc;
    bit  m_line_on, m_lpend, m_fpend, m_field;
    bit  e_valid, e_ls, e_fs, e_field;
    bit [PW-1:0] e_data;

    function automatic int f_vd(); return {act[0][7:6], act[1]}; endfunction
    function automatic int f_va(); return {act[0][5:4], act[2]}; endfunction
    function automatic int f_hd(); return {act[0][3:2], act[3]}; endfunction
    function automatic int f_ha(); return {act[0][1:0], act[4]}; endfunction
    function automatic int eff(input int s); return (s < 256) ? 256 : s; endfunction
    function automatic int f_vs(); return eff({act[5][7:4], act[6]}); endfunction
    function automatic int f_hs(); return eff({act[5][3:0], act[7]}); endfunction

    task automatic check(input string what, input int a, input int e);
        checks++;
        if (a != e) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, a, e);
        end
    endtask

    task automatic model_reset();
        shadow = '{8'h12, 8'h18, 8'h20, 8'h03, 8'hD0, 8'h11, 8'h00, 8'h00};
        act = shadow;
        m_vcnt = 0; m_vacc = 0; m_hcnt = 0; m_hacc = 0;
        m_line_on = 0; m_lpend = 0; m_fpend = 0; m_field = 0;
        e_valid = 0; e_ls = 0; e_fs = 0; e_field = 0; e_data = '0;
    endtask

    // one clock: compare last cycle's expectation, then drive and predict
    task automatic cycle(input bit hs, input bit vs, input bit pv, input bit fld,
                         input bit wr, input int addr, input int wdata);
        bit [PW-1:0] d;
        @(negedge clk);
        check("valid", out_valid, e_valid);
        if (e_valid) check("data", out_data, e_data);
        check("R10 line_start", out_line_start, e_ls);
        check("R10 field_start", out_field_start, e_fs);
        check("R10 field", out_field, e_field);
        if (out_valid) nemit++;
        d = PW'($urandom);
        hsync = hs; vsync = vs; pix_valid = pv; field_in = fld; pix_data = d;
        cfg_wr = wr; cfg_addr = 3'(addr); cfg_data = 8'(wdata);
        e_valid = 0; e_ls = 0; e_fs = 0;
        if (vs) begin
            act = shadow;
            m_vcnt = 0; m_vacc = 0; m_hcnt = 0; m_hacc = 0;
            m_line_on = 0; m_lpend = 0; m_fpend = 1; m_field = fld;
        end else if (hs) begin
            bit in_w = (m_vcnt >= f_vd()) && (m_vcnt < f_vd() + f_va());
            bit k = 0;
            if (in_w) begin
                int s = m_vacc + 256;
                k = (s >= f_vs());
                m_vacc = k ? s - f_vs() : s;
            end
            m_line_on = in_w && k;
            if (m_vcnt < 2047) m_vcnt++;
            m_hcnt = 0; m_hacc = 0; m_lpend = 1;
        end else if (pv) begin
            bit in_w = (m_hcnt >= f_hd()) && (m_hcnt < f_hd() + f_ha());
            bit k = 0;
            if (in_w) begin
                int s = m_hacc + 256;
                k = (s >= f_hs());
                m_hacc = k ? s - f_hs() : s;
            end
            if (m_hcnt < 2047) m_hcnt++;
            if (in_w && k && m_line_on) begin
                e_valid = 1; e_data = d; e_ls = m_lpend; e_fs = m_fpend;
                m_lpend = 0; m_fpend = 0;
            end
        end
        e_field = m_field;
        if (wr) shadow[addr] = 8'(wdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wreg(input int a, input int v);
        cycle(0, 0, 0, 0, 1, a, v);
    endtask

    // R8: map and packing of the register file
    task automatic set_cfg(input int hd, input int ha, input int vd, input int va,
                           input int hsc, input int vsc);
        wreg(0, ((vd >> 8) << 6) | (((va >> 8) & 3) << 4) | (((hd >> 8) & 3) << 2) | ((ha >> 8) & 3));
        wreg(1, vd & 255); wreg(2, va & 255); wreg(3, hd & 255); wreg(4, ha & 255);
        wreg(5, (((vsc >> 8) & 15) << 4) | ((hsc >> 8) & 15));
        wreg(6, vsc & 255); wreg(7, hsc & 255);
    endtask

    task automatic line(input int npix, input int gap_pct);
        cycle(1, 0, $urandom_range(0, 1), 0, 0, 0, 0);   // R11: pixel in sync cycle
        for (int p = 0; p < npix; p++) begin
            while ($urandom_range(0, 99) < gap_pct) idle(1);
            cycle(0, 0, 1, 0, 0, 0, 0);
        end
        idle(1);
    endtask

    task automatic field(input bit fld, input int nlines, input int npix,
                         input int first_pix_line, input int gap_pct);
        cycle(0, 1, $urandom_range(0, 1), fld, 0, 0, 0);
        for (int l = 0; l < nlines; l++)
            line((l >= first_pix_line) ? npix : 0, gap_pct);
    endtask

    task automatic count_check(input string what, input int e);
        idle(2);
        check(what, nemit, e);
        nemit = 0;
    endtask

    initial begin
        void'($urandom(32'd20240613));
        model_reset();
        rst = 1; hsync = 0; vsync = 0; pix_valid = 0; field_in = 0;
        cfg_wr = 0; cfg_addr = 0; cfg_data = 0; pix_data = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        tag = "R1";
        check("R1 out_valid", out_valid, 0);
        check("R1 line_start", out_line_start, 0);
        check("R1 field_start", out_field_start, 0);
        check("R1 out_field", out_field, 0);
        idle(3);
        nemit = 0;

        // R12: defaults, lines 24,25 kept, pixels 3..7
        tag = "R12 defaults";
        field(1, 26, 8, 0, 0);
        count_check("R12 count", 10);

        // R2 R3 R5: plain window, unity scale
        tag = "R2 R3 R5 window";
        set_cfg(2, 5, 1, 3, 256, 256);
        field(0, 6, 10, 0, 30);
        count_check("R5 count", 15);

        // R9: mid-field write does not touch the current field
        tag = "R9 commit";
        cycle(0, 1, 0, 1, 0, 0, 0);
        line(10, 0); line(10, 0); line(10, 0);
        wreg(4, 8);
        line(10, 0); line(10, 0); line(10, 0);
        count_check("R9 old field", 15);
        field(0, 6, 10, 0, 0);
        count_check("R9 new field", 24);

        // R4 R6: decimation
        tag = "R4 R6 decimation";
        set_cfg(0, 12, 0, 8, 512, 768);
        field(1, 10, 12, 0, 20);
        count_check("R6 count 2:1 x 3:1", 12);
        set_cfg(0, 12, 0, 2, 384, 256);
        field(0, 3, 12, 0, 20);
        count_check("R4 count 3:2", 16);

        // R7: scale below unity
        tag = "R7 low scale";
        set_cfg(1, 6, 0, 2, 100, 0);
        field(1, 3, 8, 0, 10);
        count_check("R7 count", 12);

        // R8: high bits in packed registers
        tag = "R8 high bits";
        set_cfg(260, 12, 257, 2, 768, 256);
        field(0, 259, 280, 256, 0);
        count_check("R8 count", 8);

        // R11: random fields with sync-cycle pixels
        tag = "R11 random";
        for (int f = 0; f < 12; f++) begin
            int hd = $urandom_range(0, 6), ha = $urandom_range(1, 20);
            int vd = $urandom_range(0, 3), va = $urandom_range(1, 8);
            set_cfg(hd, ha, vd, va, $urandom_range(0, 1000), $urandom_range(0, 900));
            field(1'(f), vd + va + 2, hd + ha + 3, 0, 25);
        end
        idle(4);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog timeout actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule